// File: doc/BRIEF.md
# PAUSE Frame Transmit Generator

This block builds a complete minimum-size MAC Control PAUSE frame and sends it one byte at a time to a downstream transmit path. A single-cycle request starts a frame. The request carries a 16-bit pause quanta value; a value of zero tells the link partner to resume traffic at once. The block also takes the station's own 48-bit address.

Each frame has the following parts, in order:
- the preamble and start delimiter;
- the reserved multicast control destination;
- the station source address;
- the control type and the pause opcode;
- the quanta value;
- the zero padding;
- a CRC-32 frame check sequence, computed inline as the bytes go out.

The output is a byte stream with valid, start-of-frame and end-of-frame markers. A downstream ready input paces the stream. A request that arrives while a frame is under way is held. One more frame then follows, using the quanta value of the latest such request. A busy flag shows that a frame is being sent or is waiting to start.

Top module: `pause_tx_gen`

## Requirements
- R1: While reset is high, and afterwards until a request is seen, `valid_o` and `busy_o` are low.
- R2: A frame starts with seven bytes 0x55 and then one byte 0xD5. `sof_o` is high only on the first 0x55.
- R3: Bytes 8 to 13 are 01 80 C2 00 00 01. Bytes 14 to 19 are the source address, bits 47:40 first, taken from `src_mac_i` in the cycle the frame starts.
- R4: Bytes 20 to 25 are 0x88, 0x08, 0x00, 0x01 and then the quanta value, high byte first.
- R5: Bytes 26 to 67 are zero. Bytes 68 to 71 are the complement of a CRC-32 taken over bytes 8 to 67, least-significant byte first. The CRC uses reflected polynomial 0xEDB88320 and an all-ones start value. `eof_o` is high only on byte 71, so every frame is 72 bytes.
- R6: A quanta value of zero gives a full frame whose parameter bytes are 00 00.
- R7: While `valid_o` is high and `rdy_i` is low, the next cycle keeps `valid_o`, `data_o`, `sof_o` and `eof_o` unchanged.
- R8: Any number of requests made while busy give exactly one further frame, which carries the quanta value of the last of them.
- R9: `busy_o` rises in the cycle after a request is sampled. `valid_o` with `sof_o` follows one cycle later. `busy_o` stays high whenever `valid_o` is high, and falls once the last byte is accepted with nothing pending.
- R10: After the last byte of a frame is accepted, `valid_o` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request for one PAUSE frame |
| quanta_i | input | 16 | Pause duration in 512-bit-time units, sampled with `req_i` |
| src_mac_i | input | 48 | Station source address |
| rdy_i | input | 1 | Downstream accepts the current byte |
| data_o | output | 8 | Frame byte |
| valid_o | output | 1 | `data_o` holds a frame byte |
| sof_o | output | 1 | First byte of the frame |
| eof_o | output | 1 | Last byte of the frame |
| busy_o | output | 1 | Frame in progress or pending |

## Verification
The bench builds the block with its default lengths: a seven-byte preamble and 42 pad bytes. This gives the full 72-byte frame and drives the byte index to its top value on every frame. With these values, every field boundary is reached, including the last pad byte and all four check-sequence bytes. Seeded ready stalls fall on arbitrary field positions. A back-to-back pair of frames exercises both the inter-frame gap and the collapse of several pending requests.

// File: rtl/pause_pkg.sv
package pause_pkg;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam logic [47:0] CTRL_DST   = 48'h0180C2000001;
    localparam logic [15:0] CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] PAUSE_OPC  = 16'h0001;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;

    localparam int ADDR_LEN = 6;
    localparam int WORD_LEN = 2;
    localparam int FCS_LEN  = 4;
    localparam int NUM_FLD  = 9;

    typedef enum logic [3:0] {
        FLD_PRE, FLD_SFD, FLD_DST, FLD_SRC, FLD_TYP,
        FLD_OPC, FLD_PRM, FLD_PAD, FLD_FCS
    } fld_e;

    typedef struct packed {
        fld_e       fld;
        logic [2:0] off;
    } pos_t;

    // byte k of a 48-bit word, byte 0 being bits 7:0
    function automatic logic [7:0] pick_byte(logic [47:0] w, logic [2:0] k);
        return w[{k, 3'b000} +: 8];
    endfunction

    // one byte through the reflected CRC-32 register
    function automatic logic [31:0] crc32_byte(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pause_seq.sv
module pause_seq
    import pause_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAD_LEN = 42
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic rdy_i,
    output logic active_o,
    output logic pending_o,
    output logic start_o,
    output logic step_o,
    output logic first_o,
    output logic last_o,
    output pos_t pos_o
);

    localparam int FRM_LEN  = PRE_LEN + 1 + 2 * ADDR_LEN + 3 * WORD_LEN + PAD_LEN + FCS_LEN;
    localparam int LAST_IDX = FRM_LEN - 1;
    localparam int IDX_W    = $clog2(FRM_LEN + 1);
    localparam int BASE [NUM_FLD] = '{
        0,
        PRE_LEN,
        PRE_LEN + 1,
        PRE_LEN + 1 + ADDR_LEN,
        PRE_LEN + 1 + 2 * ADDR_LEN,
        PRE_LEN + 1 + 2 * ADDR_LEN + WORD_LEN,
        PRE_LEN + 1 + 2 * ADDR_LEN + 2 * WORD_LEN,
        PRE_LEN + 1 + 2 * ADDR_LEN + 3 * WORD_LEN,
        PRE_LEN + 1 + 2 * ADDR_LEN + 3 * WORD_LEN + PAD_LEN
    };

    logic             active_q;
    logic             pend_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] rel;
    int               base;

    assign start_o   = !active_q && pend_q;
    assign step_o    = active_q && rdy_i;
    assign first_o   = active_q && (idx_q == '0);
    assign last_o    = active_q && (idx_q == IDX_W'(LAST_IDX));
    assign active_o  = active_q;
    assign pending_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            idx_q    <= '0;
        end else begin
            pend_q <= req_i | (pend_q & ~start_o);
            if (start_o) begin
                active_q <= 1'b1;
                idx_q    <= '0;
            end else if (step_o) begin
                if (last_o) active_q <= 1'b0;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // the last field base not above the index names the field
    always_comb begin
        pos_o.fld = FLD_PRE;
        base      = 0;
        for (int i = 0; i < NUM_FLD; i++) begin
            if (int'(idx_q) >= BASE[i]) begin
                pos_o.fld = fld_e'(4'(i));
                base      = BASE[i];
            end
        end
        rel       = idx_q - IDX_W'(base);
        pos_o.off = rel[2:0];
    end

endmodule

// File: rtl/pause_crc32.sv
module pause_crc32
    import pause_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) crc_q <= CRC_INIT;
        else if (en_i)      crc_q <= crc32_byte(crc_q, byte_i);
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/pause_tx_gen.sv
module pause_tx_gen
    import pause_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAD_LEN = 42
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [15:0] quanta_i,
    input  logic [47:0] src_mac_i,
    input  logic        rdy_i,
    output logic [7:0]  data_o,
    output logic        valid_o,
    output logic        sof_o,
    output logic        eof_o,
    output logic        busy_o
);

    logic        active, pending, start, step, first, last;
    pos_t        pos;
    logic        crc_en;
    logic [31:0] crc;
    logic [15:0] quanta_pend_q;
    logic [15:0] quanta_cur_q;
    logic [47:0] src_q;
    logic [7:0]  byte_d;

    pause_seq #(.PRE_LEN(PRE_LEN), .PAD_LEN(PAD_LEN)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .rdy_i    (rdy_i),
        .active_o (active),
        .pending_o(pending),
        .start_o  (start),
        .step_o   (step),
        .first_o  (first),
        .last_o   (last),
        .pos_o    (pos)
    );

    assign crc_en = step && (pos.fld inside {FLD_DST, FLD_SRC, FLD_TYP, FLD_OPC, FLD_PRM, FLD_PAD});

    pause_crc32 i_crc (
        .clk    (clk),
        .rst    (rst),
        .clear_i(start),
        .en_i   (crc_en),
        .byte_i (byte_d),
        .crc_o  (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quanta_pend_q <= '0;
            quanta_cur_q  <= '0;
            src_q         <= '0;
        end else begin
            if (req_i) quanta_pend_q <= quanta_i;
            if (start) begin
                quanta_cur_q <= quanta_pend_q;
                src_q        <= src_mac_i;
            end
        end
    end

    always_comb begin
        unique case (pos.fld)
            FLD_PRE: byte_d = PRE_BYTE;
            FLD_SFD: byte_d = SFD_BYTE;
            FLD_DST: byte_d = pick_byte(CTRL_DST, 3'd5 - pos.off);
            FLD_SRC: byte_d = pick_byte(src_q, 3'd5 - pos.off);
            FLD_TYP: byte_d = pick_byte({32'h0, CTRL_TYPE}, 3'd1 - pos.off);
            FLD_OPC: byte_d = pick_byte({32'h0, PAUSE_OPC}, 3'd1 - pos.off);
            FLD_PRM: byte_d = pick_byte({32'h0, quanta_cur_q}, 3'd1 - pos.off);
            FLD_PAD: byte_d = 8'h00;
            FLD_FCS: byte_d = pick_byte({16'h0, ~crc}, pos.off);
            default: byte_d = 8'h00;
        endcase
    end

    assign data_o  = byte_d;
    assign valid_o = active;
    assign sof_o   = first;
    assign eof_o   = last;
    assign busy_o  = active | pending;

endmodule

// File: rtl/pause_tx_gen_chk.sv
module pause_tx_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic       rdy_i,
    input logic [7:0] data_o,
    input logic       valid_o,
    input logic       sof_o,
    input logic       eof_o,
    input logic       busy_o
);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !rdy_i) |=> (valid_o && $stable(data_o) && $stable(sof_o) && $stable(eof_o)));

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> busy_o);

    // R9
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> busy_o);

    // R2
    first_sof_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> sof_o);

    // R10
    frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && rdy_i && eof_o) |=> !valid_o);

    // R5
    marks_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(sof_o && eof_o));

endmodule

bind pause_tx_gen pause_tx_gen_chk i_pause_tx_gen_chk (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .rdy_i  (rdy_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .sof_o  (sof_o),
    .eof_o  (eof_o),
    .busy_o (busy_o)
);

// File: tb/test_pause_tx_gen.sv
module test_pause_tx_gen;

    localparam int FRM = 72;

    typedef struct packed {
        logic [15:0] q;
        logic [47:0] mac;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [15:0] quanta = '0;
    logic [47:0] mac = '0;
    logic        rdy = 1'b1;
    logic [7:0]  data;
    logic        valid, sof, eof, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int frames_done = 0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    exp_t       exp_q[$];
    logic [7:0] cap [FRM];
    int         cap_n = 0;
    int         sof_cnt = 0;
    logic [7:0] expf [FRM];

    bit         prev_hold = 1'b0;
    bit         prev_end = 1'b0;
    logic [7:0] prev_data = '0;
    logic       prev_sof = 1'b0, prev_eof = 1'b0;

    always #10 clk = ~clk;

    pause_tx_gen i_pause_tx_gen (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .quanta_i (quanta),
        .src_mac_i(mac),
        .rdy_i    (rdy),
        .data_o   (data),
        .valid_o  (valid),
        .sof_o    (sof),
        .eof_o    (eof),
        .busy_o   (busy)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic build_expected(input logic [15:0] q, input logic [47:0] m);
        logic [31:0] c;
        logic [47:0] dst = 48'h0180C2000001;
        for (int i = 0; i < 7; i++) expf[i] = 8'h55;
        expf[7] = 8'hD5;
        for (int i = 0; i < 6; i++) expf[8 + i]  = dst[47 - 8*i -: 8];
        for (int i = 0; i < 6; i++) expf[14 + i] = m[47 - 8*i -: 8];
        expf[20] = 8'h88; expf[21] = 8'h08; expf[22] = 8'h00; expf[23] = 8'h01;
        expf[24] = q[15:8]; expf[25] = q[7:0];
        for (int i = 26; i < 68; i++) expf[i] = 8'h00;
        c = 32'hFFFFFFFF;
        for (int i = 8; i < 68; i++) c = ref_crc(c, expf[i]);
        c = ~c;
        for (int i = 0; i < 4; i++) expf[68 + i] = c[8*i +: 8];
    endtask

    function automatic string tag_of(input int i, input logic [15:0] q);
        if (i < 8)  return "R2 preamble/SFD";
        if (i < 20) return "R3 addresses";
        if (i < 24) return "R4 type/opcode";
        if (i < 26) return (q == 16'h0) ? "R6 release parameter" : "R4 parameter";
        if (i < 68) return "R5 pad";
        return "R5 FCS";
    endfunction

    task automatic check_frame();
        exp_t e;
        chk(exp_q.size() > 0, "R8 frame with no request pending", 32'(exp_q.size()), 32'd1);
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        build_expected(e.q, e.mac);
        chk(cap_n == FRM, "R5 frame length", 32'(cap_n), FRM);
        chk(sof_cnt == 1, "R2 one sof per frame", 32'(sof_cnt), 32'd1);
        for (int i = 0; i < FRM; i++) begin
            if (i < cap_n)
                chk(cap[i] == expf[i], tag_of(i, e.q), {24'h0, cap[i]}, {24'h0, expf[i]});
        end
        frames_done++;
    endtask

    // drives rdy, then records what the coming edge will transfer
    always @(negedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rdy  = stall_en ? (lfsr[1] | lfsr[4]) : 1'b1;
        if (!rst) begin
            if (prev_hold)
                chk(valid && data == prev_data && sof == prev_sof && eof == prev_eof,
                    "R7 output held under stall", {23'h0, valid, data}, {23'h1, prev_data});
            if (prev_end)
                chk(!valid, "R10 gap after last byte", {31'h0, valid}, 32'd0);
            prev_hold = valid && !rdy;
            prev_data = data;
            prev_sof  = sof;
            prev_eof  = eof;
            prev_end  = valid && rdy && eof;
            if (valid && rdy) begin
                if (sof) begin
                    cap_n   = 0;
                    sof_cnt = 0;
                end
                if (sof) sof_cnt++;
                if (cap_n < FRM) cap[cap_n] = data;
                cap_n++;
                if (eof) check_frame();
            end
        end
    end

    task automatic request(input logic [15:0] q);
        @(negedge clk);
        req    = 1'b1;
        quanta = q;
        @(negedge clk);
        req    = 1'b0;
    endtask

    task automatic wait_idle(input int target);
        while (!(busy == 1'b0 && frames_done >= target)) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(frames_done == target, "R8 frame count", 32'(frames_done), 32'(target));
        chk(!busy && !valid, "R9 idle after frame", {30'h0, busy, valid}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(!valid && !busy, "R1 outputs low in reset", {30'h0, valid, busy}, 32'd0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(!valid && !busy, "R1 idle with no request", {30'h0, valid, busy}, 32'd0);
    endtask

    task automatic t_single();
        mac = 48'h02AABBCCDDEE;
        exp_q.push_back('{q: 16'h1234, mac: 48'h02AABBCCDDEE});
        request(16'h1234);
        chk(busy && !valid, "R9 busy in cycle after request", {30'h0, busy, valid}, 32'd2);
        @(negedge clk);
        chk(valid && sof && data == 8'h55, "R2 first byte with sof",
            {22'h0, valid, sof, data}, {22'h0, 2'b11, 8'h55});
        wait_idle(1);
    endtask

    task automatic t_release();
        mac = 48'h0A1B2C3D4E5F;
        exp_q.push_back('{q: 16'h0000, mac: 48'h0A1B2C3D4E5F});
        request(16'h0000);
        wait_idle(2);
    endtask

    task automatic t_stall();
        mac      = 48'hFEDCBA987654;
        stall_en = 1'b1;
        exp_q.push_back('{q: 16'hFFFF, mac: 48'hFEDCBA987654});
        request(16'hFFFF);
        wait_idle(3);
        stall_en = 1'b0;
    endtask

    task automatic t_busy_requests();
        mac = 48'h001122334455;
        exp_q.push_back('{q: 16'h0100, mac: 48'h001122334455});
        exp_q.push_back('{q: 16'h0300, mac: 48'h001122334455});
        request(16'h0100);
        while (!valid) @(negedge clk);
        repeat (10) @(negedge clk);
        request(16'h0200);
        repeat (5) @(negedge clk);
        request(16'h0300);
        chk(busy, "R8 busy while frame and request pending", {31'h0, busy}, 32'd1);
        wait_idle(5);
        chk(exp_q.size() == 0, "R8 all expected frames seen", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_release();
        t_stall();
        t_busy_requests();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule